// File: doc/BRIEF.md
# Configuration Image Header Parser

This block sits at the front of a configuration-load path and reads a configuration image one byte per cycle through a valid/ready input stream. It first checks a fixed 13-byte signature. It then reads four tagged text sections in a fixed order: design name, device part, build date and build time. Each section has a 16-bit big-endian length, and its text is kept in a small per-section buffer. The last header item is a length section, marked by the byte 0x65, which carries a 32-bit big-endian payload size.

After the header, the block becomes a pass-through. It forwards exactly the declared number of payload bytes to an output stream, and the downstream stall propagates back to the input. Once the last payload byte has moved, it raises `done` and then takes in and discards any further bytes.

A header fault stops parsing and holds a 2-bit error code until a synchronous `restart` is applied. The captured text can be read at any time through a combinational read port. Reading at or beyond a section's stored length returns 0x00, so each section reads back as a zero-terminated string.

The control path is one state machine with these states:
- `ST_SIG`: compares the signature byte by byte.
- `ST_FTAG`, `ST_FLEN_HI`, `ST_FLEN_LO`, `ST_FBODY`: the tag, length and text of the current section.
- `ST_LTAG`: checks the length-section tag.
- `ST_PLEN`: collects the four length bytes.
- `ST_PAYLOAD`: pass-through.
- `ST_DONE`: payload finished.
- `ST_ERR_SIG`, `ST_ERR_SIZE`, `ST_ERR_TAG`: error states.

Every transition fires on an accepted byte, as follows:
- `ST_SIG` goes to `ST_ERR_SIG` on a mismatch, and to `ST_FTAG` after byte 12.
- `ST_FTAG` goes to `ST_FLEN_HI`, and `ST_FLEN_HI` goes to `ST_FLEN_LO`.
- `ST_FLEN_LO` goes to `ST_ERR_SIZE` if the length is too large. If the length is zero it goes straight on to the next section (`ST_FTAG`), or to `ST_LTAG` after the fourth section. Otherwise it goes to `ST_FBODY`.
- `ST_FBODY` moves to the next section, or to `ST_LTAG`, after its last text byte.
- `ST_LTAG` goes to `ST_PLEN` on 0x65 and to `ST_ERR_TAG` on any other value.
- `ST_PLEN` goes to `ST_DONE` after a zero length, or to `ST_PAYLOAD` after a non-zero length.
- `ST_PAYLOAD` goes to `ST_DONE` on the last byte.
- `restart` or reset returns every state to `ST_SIG`.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After reset or after a cycle with `restart` high, the outputs are `in_ready`=1, `out_valid`=0, `done`=0, `len_valid`=0 and `err_code`=0.
- R2: The first 13 accepted bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. On the first byte that differs, `err_code` becomes 1 from the next cycle on.
- R3: Each of the four sections is stored in the buffer chosen by `rd_sel` (0 = name, 1 = part, 2 = date, 3 = time). The byte at position k reads back on `rd_data`, and any address at or beyond the section length reads 0x00.
- R4: A section length is formed from a high byte followed by a low byte. If the length is greater than or equal to BUF_BYTES (default 64), `err_code` becomes 2. A length of BUF_BYTES-1 is accepted.
- R5: If the byte after the fourth section is not 0x65, `err_code` becomes 3.
- R6: `payload_len` holds the four bytes after the 0x65 tag, most significant byte first. `len_valid` rises in the cycle after the fourth byte and stays stable until restart.
- R7: In the payload phase, `out_valid` follows `in_valid`, `out_data` equals `in_data`, and `in_ready` equals `out_ready`, so a stall holds the input.
- R8: After exactly `payload_len` forwarded bytes, `done` is 1 from the next cycle on. If the length is zero, `done` is 1 directly after the last length byte. Later bytes are accepted but are not forwarded.
- R9: An error code and the done state persist regardless of input until `restart`. `restart` also empties all four section buffers.
- R10: The tag byte that opens each text section is not checked; any value is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to the start state; clears errors and buffers |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte will be taken this cycle |
| out_valid | output | 1 | Payload byte present |
| out_data | output | 8 | Payload byte |
| out_ready | input | 1 | Downstream can take a byte |
| payload_len | output | 32 | Declared payload length |
| len_valid | output | 1 | `payload_len` is complete |
| payload_active | output | 1 | Parser is in the payload phase |
| done | output | 1 | All payload bytes have been forwarded |
| err_code | output | 2 | 0 none, 1 signature, 2 section too long, 3 wrong length tag |
| rd_sel | input | 2 | Section selected for reading |
| rd_addr | input | $clog2(BUF_BYTES) | Byte position to read |
| rd_data | output | 8 | Stored byte, or 0x00 at or past the section end |

## Verification
The results fall into two groups by timing.
- **Registered results:** `err_code`, `len_valid`, `payload_len`, `done` and `payload_active` change one cycle after the rising edge that accepts the deciding byte. The bench drives each byte on a falling edge, lets the accepting rising edge pass, and samples these at the following falling edge.
- **Combinational results:** the pass-through outputs `out_valid`, `out_data` and the stalled `in_ready`, as well as `rd_data`, follow their inputs in the same cycle. The bench checks them shortly after driving the inputs and before the rising edge.

Stall and discard checks look at the outputs while the stimulus is still applied.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int         SIG_BYTES  = 13;
    localparam int         NUM_FIELDS = 4;
    localparam logic [7:0] LEN_TAG    = 8'h65;

    localparam logic [1:0] ERR_NONE = 2'd0;
    localparam logic [1:0] ERR_SIG  = 2'd1;
    localparam logic [1:0] ERR_SIZE = 2'd2;
    localparam logic [1:0] ERR_TAG  = 2'd3;

    typedef enum logic [3:0] {
        ST_SIG,
        ST_FTAG,
        ST_FLEN_HI,
        ST_FLEN_LO,
        ST_FBODY,
        ST_LTAG,
        ST_PLEN,
        ST_PAYLOAD,
        ST_DONE,
        ST_ERR_SIG,
        ST_ERR_SIZE,
        ST_ERR_TAG
    } parse_state_t;

    // Expected signature byte at a given position of the image.
    function automatic logic [7:0] sig_byte(input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h00;
            4'd1:    b = 8'h09;
            4'd2:    b = 8'h0F;
            4'd3:    b = 8'hF0;
            4'd4:    b = 8'h0F;
            4'd5:    b = 8'hF0;
            4'd6:    b = 8'h0F;
            4'd7:    b = 8'hF0;
            4'd8:    b = 8'h0F;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h00;
            4'd11:   b = 8'h00;
            4'd12:   b = 8'h01;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cfg_hdr_fieldbuf.sv
module cfg_hdr_fieldbuf #(
    parameter int BUF_BYTES  = 64,
    parameter int NUM_FIELDS = 4,
    localparam int ADDR_W = $clog2(BUF_BYTES),
    localparam int CNT_W  = $clog2(BUF_BYTES + 1),
    localparam int SEL_W  = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [7:0]        wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam logic [CNT_W-1:0] FILL_MAX = CNT_W'(BUF_BYTES - 1);

    logic [7:0] rd_bytes [NUM_FIELDS];

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        logic [7:0]       mem [BUF_BYTES];
        logic [CNT_W-1:0] fill;
        logic             hit;

        // One slot is always kept free, so the string stays terminated.
        assign hit = wr_en && (wr_sel == SEL_W'(g)) && (fill < FILL_MAX);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fill <= '0;
            end else if (clear) begin
                fill <= '0;
            end else if (hit) begin
                fill <= fill + CNT_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (hit && !clear) begin
                mem[fill[ADDR_W-1:0]] <= wr_data;
            end
        end

        // Anything past the filled part reads as the terminator.
        assign rd_bytes[g] = (CNT_W'(rd_addr) < fill) ? mem[rd_addr] : 8'h00;
    end

    assign rd_data = rd_bytes[rd_sel];

endmodule

// File: rtl/cfg_hdr_paylen.sv
module cfg_hdr_paylen #(
    parameter int LEN_BYTES = 4,
    localparam int LEN_W = 8 * LEN_BYTES
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic [7:0]       shift_byte,
    input  logic             take_en,
    output logic [LEN_W-1:0] plen,
    output logic             zero_next,
    output logic             last
);

    logic [LEN_W-1:0] taken;
    logic [LEN_W-1:0] plen_shifted;

    assign plen_shifted = {plen[LEN_W-9:0], shift_byte};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            plen <= '0;
        end else if (clear) begin
            plen <= '0;
        end else if (shift_en) begin
            plen <= plen_shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken <= '0;
        end else if (clear) begin
            taken <= '0;
        end else if (take_en) begin
            taken <= taken + LEN_W'(1);
        end
    end

    assign zero_next = (plen_shifted == '0);
    assign last      = (taken == (plen - LEN_W'(1)));

endmodule

// File: rtl/cfg_hdr_fsm.sv
module cfg_hdr_fsm
    import cfg_hdr_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    parameter int LEN_BYTES = 4,
    localparam int PIDX_W = (LEN_BYTES > 1) ? $clog2(LEN_BYTES) : 1,
    localparam int SEL_W  = $clog2(NUM_FIELDS)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             out_ready,
    input  logic             plen_zero_next,
    input  logic             pay_last,
    output logic             in_ready,
    output logic             out_valid,
    output logic             fld_we,
    output logic [SEL_W-1:0] fld_sel,
    output logic             plen_shift,
    output logic             pay_take,
    output logic [1:0]       err_code,
    output logic             len_valid,
    output logic             payload_active,
    output logic             done
);

    localparam logic [16:0] CAP = 17'(BUF_BYTES);

    parse_state_t      state, state_nx;
    logic [3:0]        sig_idx;
    logic [SEL_W-1:0]  fld_idx;
    logic [7:0]        len_hi;
    logic [15:0]       body_left;
    logic [PIDX_W-1:0] plen_idx;

    logic        accept;
    logic [15:0] field_len;
    logic        oversize;
    logic        last_field;
    logic        field_end;

    assign accept     = in_valid && in_ready;
    assign field_len  = {len_hi, in_data};
    assign oversize   = ({1'b0, field_len} >= CAP);
    assign last_field = (fld_idx == SEL_W'(NUM_FIELDS - 1));
    assign field_end  = accept &&
        (((state == ST_FLEN_LO) && !oversize && (field_len == 16'd0)) ||
         ((state == ST_FBODY) && (body_left == 16'd1)));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SIG;
        end else if (restart) begin
            state <= ST_SIG;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SIG: begin
                if (accept) begin
                    if (in_data != sig_byte(sig_idx)) begin
                        state_nx = ST_ERR_SIG;
                    end else if (sig_idx == 4'(SIG_BYTES - 1)) begin
                        state_nx = ST_FTAG;
                    end
                end
            end
            ST_FTAG: begin
                if (accept) state_nx = ST_FLEN_HI;
            end
            ST_FLEN_HI: begin
                if (accept) state_nx = ST_FLEN_LO;
            end
            ST_FLEN_LO: begin
                if (accept) begin
                    if (oversize) begin
                        state_nx = ST_ERR_SIZE;
                    end else if (field_len == 16'd0) begin
                        state_nx = last_field ? ST_LTAG : ST_FTAG;
                    end else begin
                        state_nx = ST_FBODY;
                    end
                end
            end
            ST_FBODY: begin
                if (field_end) state_nx = last_field ? ST_LTAG : ST_FTAG;
            end
            ST_LTAG: begin
                if (accept) state_nx = (in_data == LEN_TAG) ? ST_PLEN : ST_ERR_TAG;
            end
            ST_PLEN: begin
                if (accept && (plen_idx == PIDX_W'(LEN_BYTES - 1))) begin
                    state_nx = plen_zero_next ? ST_DONE : ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                if (accept && pay_last) state_nx = ST_DONE;
            end
            ST_DONE, ST_ERR_SIG, ST_ERR_SIZE, ST_ERR_TAG: begin
                state_nx = state;
            end
            default: state_nx = ST_SIG;
        endcase
    end

    // Position counters of the header walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_idx   <= '0;
            fld_idx   <= '0;
            len_hi    <= '0;
            body_left <= '0;
            plen_idx  <= '0;
        end else if (restart) begin
            sig_idx   <= '0;
            fld_idx   <= '0;
            len_hi    <= '0;
            body_left <= '0;
            plen_idx  <= '0;
        end else begin
            if (accept && (state == ST_SIG)) sig_idx <= sig_idx + 4'd1;
            if (accept && (state == ST_FLEN_HI)) len_hi <= in_data;
            if (accept && (state == ST_FLEN_LO)) body_left <= field_len;
            if (accept && (state == ST_FBODY)) body_left <= body_left - 16'd1;
            if (accept && (state == ST_PLEN)) plen_idx <= plen_idx + PIDX_W'(1);
            if (field_end && !last_field) fld_idx <= fld_idx + SEL_W'(1);
        end
    end

    // Outputs decoded from the state
    always_comb begin
        in_ready       = 1'b1;
        out_valid      = 1'b0;
        err_code       = ERR_NONE;
        len_valid      = 1'b0;
        payload_active = 1'b0;
        done           = 1'b0;
        unique case (state)
            ST_PAYLOAD: begin
                in_ready       = out_ready;
                out_valid      = in_valid;
                len_valid      = 1'b1;
                payload_active = 1'b1;
            end
            ST_DONE: begin
                len_valid = 1'b1;
                done      = 1'b1;
            end
            ST_ERR_SIG:  err_code = ERR_SIG;
            ST_ERR_SIZE: err_code = ERR_SIZE;
            ST_ERR_TAG:  err_code = ERR_TAG;
            default: begin
                in_ready = 1'b1;
            end
        endcase
    end

    assign fld_we     = accept && (state == ST_FBODY);
    assign fld_sel    = fld_idx;
    assign plen_shift = accept && (state == ST_PLEN);
    assign pay_take   = accept && (state == ST_PAYLOAD);

endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
    import cfg_hdr_pkg::*;
#(
    parameter int BUF_BYTES = 64,
    localparam int ADDR_W = $clog2(BUF_BYTES)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic [31:0]       payload_len,
    output logic              len_valid,
    output logic              payload_active,
    output logic              done,
    output logic [1:0]        err_code,
    input  logic [1:0]        rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int LEN_BYTES = 4;

    logic       fld_we;
    logic [1:0] fld_sel;
    logic       plen_shift;
    logic       pay_take;
    logic       plen_zero_next;
    logic       pay_last;

    cfg_hdr_fsm #(
        .BUF_BYTES (BUF_BYTES),
        .LEN_BYTES (LEN_BYTES)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .restart        (restart),
        .in_valid       (in_valid),
        .in_data        (in_data),
        .out_ready      (out_ready),
        .plen_zero_next (plen_zero_next),
        .pay_last       (pay_last),
        .in_ready       (in_ready),
        .out_valid      (out_valid),
        .fld_we         (fld_we),
        .fld_sel        (fld_sel),
        .plen_shift     (plen_shift),
        .pay_take       (pay_take),
        .err_code       (err_code),
        .len_valid      (len_valid),
        .payload_active (payload_active),
        .done           (done)
    );

    cfg_hdr_fieldbuf #(
        .BUF_BYTES  (BUF_BYTES),
        .NUM_FIELDS (NUM_FIELDS)
    ) u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .wr_en   (fld_we),
        .wr_sel  (fld_sel),
        .wr_data (in_data),
        .rd_sel  (rd_sel),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    cfg_hdr_paylen #(
        .LEN_BYTES (LEN_BYTES)
    ) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restart),
        .shift_en   (plen_shift),
        .shift_byte (in_data),
        .take_en    (pay_take),
        .plen       (payload_len),
        .zero_next  (plen_zero_next),
        .last       (pay_last)
    );

    assign out_data = in_data;

endmodule

// File: rtl/cfg_hdr_parser_chk.sv
module cfg_hdr_parser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        restart,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] payload_len,
    input logic        len_valid,
    input logic        payload_active,
    input logic        done,
    input logic [1:0]  err_code
);

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (err_code == 2'd0 && !done && !len_valid)); // R1

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0 && !restart) |=> (err_code == $past(err_code))); // R9

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != 2'd0) |-> (!len_valid && !done && !out_valid)); // R5

    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (len_valid && !restart) |=> (len_valid && $stable(payload_len))); // R6

    AST_STALL_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R7

    AST_FWD_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_valid && payload_active)); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && in_ready)); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> done); // R9

endmodule

bind cfg_hdr_parser cfg_hdr_parser_chk u_chk (.*);

// File: tb/sim_cfg_hdr_parser.sv
module sim_cfg_hdr_parser;

    localparam int CLK_PERIOD = 10;
    localparam int BUF_BYTES  = 64;
    localparam int ADDR_W     = $clog2(BUF_BYTES);

    localparam logic [7:0] SIG_REF [13] = '{
        8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
        8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

    // {section, address, expected byte} after the good image
    localparam logic [23:0] RD_VEC [10] = '{
        {8'd0, 8'd0,  8'h41}, {8'd0, 8'd1,  8'h42}, {8'd0, 8'd2,  8'h00},
        {8'd1, 8'd0,  8'h30}, {8'd1, 8'd2,  8'h32}, {8'd1, 8'd3,  8'h00},
        {8'd2, 8'd0,  8'h00}, {8'd3, 8'd0,  8'h20}, {8'd3, 8'd62, 8'h5E},
        {8'd3, 8'd63, 8'h00}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              restart = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = 8'h00;
    logic              out_ready = 1'b1;
    logic [1:0]        rd_sel = 2'd0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              in_ready, out_valid, len_valid, payload_active, done;
    logic [7:0]        out_data, rd_data;
    logic [31:0]       payload_len;
    logic [1:0]        err_code;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_hdr_parser #(.BUF_BYTES(BUF_BYTES)) u0 (
        .clk, .rst_n, .restart, .in_valid, .in_data, .in_ready,
        .out_valid, .out_data, .out_ready, .payload_len, .len_valid,
        .payload_active, .done, .err_code, .rd_sel, .rd_addr, .rd_data);

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push_fwd(input logic [7:0] b);
        in_data  = b;
        in_valid = 1'b1;
        #1;
        check_eq("R7 out_valid", 32'(out_valid), 32'd1);
        check_eq("R7 out_data", 32'(out_data), 32'(b));
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_sig(input int bad_at);
        for (int i = 0; i < 13; i++) begin
            push((i == bad_at) ? ~SIG_REF[i] : SIG_REF[i]);
        end
    endtask

    task automatic send_field(input logic [7:0] tag, input int len, input logic [7:0] base);
        push(tag);
        push(8'(len >> 8));
        push(8'(len));
        for (int i = 0; i < len; i++) push(base + 8'(i));
    endtask

    task automatic do_restart();
        restart = 1'b1;
        @(posedge clk);
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic check_idle(input string req);
        #1;
        check_eq({req, " in_ready"}, 32'(in_ready), 32'd1);
        check_eq({req, " out_valid"}, 32'(out_valid), 32'd0);
        check_eq({req, " done"}, 32'(done), 32'd0);
        check_eq({req, " len_valid"}, 32'(len_valid), 32'd0);
        check_eq({req, " err_code"}, 32'(err_code), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_idle("R1 reset");

        // Good image; the section tags are arbitrary values (R10)
        send_sig(99);
        send_field(8'h61, 2, 8'h41);
        send_field(8'hFF, 3, 8'h30);
        send_field(8'h00, 0, 8'h00);
        send_field(8'h64, BUF_BYTES - 1, 8'h20);
        check_eq("R10 arbitrary tags no error", 32'(err_code), 32'd0);
        check_eq("R4 length BUF_BYTES-1 accepted", 32'(err_code), 32'd0);
        push(8'h65);
        push(8'h00); push(8'h00); push(8'h00);
        check_eq("R6 len_valid before last byte", 32'(len_valid), 32'd0);
        push(8'h03);
        check_eq("R6 len_valid", 32'(len_valid), 32'd1);
        check_eq("R6 payload_len", payload_len, 32'd3);

        // Stall: downstream not ready holds the input (R7)
        out_ready = 1'b0;
        in_data   = 8'hA5;
        in_valid  = 1'b1;
        #1;
        check_eq("R7 stalled in_ready", 32'(in_ready), 32'd0);
        check_eq("R7 stalled out_valid", 32'(out_valid), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        check_eq("R8 not done while stalled", 32'(done), 32'd0);

        push_fwd(8'hA5);
        push_fwd(8'h5A);
        check_eq("R8 not done early", 32'(done), 32'd0);
        push_fwd(8'hC3);
        check_eq("R8 done", 32'(done), 32'd1);

        // Trailing byte is taken but not forwarded (R8)
        in_data  = 8'h77;
        in_valid = 1'b1;
        #1;
        check_eq("R8 trailing not forwarded", 32'(out_valid), 32'd0);
        check_eq("R8 trailing accepted", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check_eq("R9 done persists", 32'(done), 32'd1);

        // Section read-back table (R3)
        foreach (RD_VEC[i]) begin
            rd_sel  = RD_VEC[i][17:16];
            rd_addr = ADDR_W'(RD_VEC[i][15:8]);
            #1;
            check_eq("R3 section read", 32'(rd_data), 32'(RD_VEC[i][7:0]));
        end

        do_restart();
        check_idle("R1 restart");
        rd_sel  = 2'd3;
        rd_addr = '0;
        #1;
        check_eq("R9 restart empties buffers", 32'(rd_data), 32'd0);

        // Bad signature at position 5 (R2)
        send_sig(5);
        check_eq("R2 signature error", 32'(err_code), 32'd1);
        push(8'h01); push(8'h65); push(8'h02);
        check_eq("R9 error sticky", 32'(err_code), 32'd1);
        do_restart();
        check_idle("R9 restart clears error");

        // Section length equal to capacity (R4)
        send_sig(99);
        push(8'h61);
        push(8'h00);
        check_eq("R4 no error before low byte", 32'(err_code), 32'd0);
        push(8'(BUF_BYTES));
        check_eq("R4 oversize error", 32'(err_code), 32'd2);
        do_restart();

        // Wrong length tag (R5)
        send_sig(99);
        for (int k = 0; k < 4; k++) send_field(8'h70 + 8'(k), 1, 8'h55);
        push(8'h66);
        check_eq("R5 tag error", 32'(err_code), 32'd3);
        check_eq("R5 no len_valid", 32'(len_valid), 32'd0);
        do_restart();

        // Zero payload length (R8)
        send_sig(99);
        for (int k = 0; k < 4; k++) send_field(8'h61, 0, 8'h00);
        push(8'h65);
        push(8'h00); push(8'h00); push(8'h00); push(8'h00);
        check_eq("R8 zero length done", 32'(done), 32'd1);
        check_eq("R8 zero length payload_len", payload_len, 32'd0);
        check_eq("R8 zero length len_valid", 32'(len_valid), 32'd1);
        do_restart();

        // Byte order of the payload length (R6)
        send_sig(99);
        for (int k = 0; k < 4; k++) send_field(8'h61, 0, 8'h00);
        push(8'h65);
        push(8'h01); push(8'h02); push(8'h03); push(8'h04);
        check_eq("R6 big-endian length", payload_len, 32'h0102_0304);
        check_eq("R7 payload phase", 32'(payload_active), 32'd1);
        do_restart();
        check_idle("R1 restart from payload");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule